// File: doc/BRIEF.md
# Serial Video Scrambler and NRZI Serializer

This block turns a stream of 10-bit parallel video words into a single serial bit per clock. It runs entirely on the bit-rate clock. Each word is taken through a valid/ready handshake and then sent over ten consecutive emission cycles, least significant bit first. Every bit passes through a self-synchronizing scrambler with generator x^9+x^4+1. The result then goes through an NRZ-to-NRZI stage with generator x+1, and only after that reaches the serial output.

An optional clipping step runs ahead of the scrambler. It folds the values reserved for timing words onto their end points, so the scrambler only ever sees clipped data.

The input side follows valid/ready rules. A word transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` never depends on `in_valid`. While `in_valid` is high and `in_ready` is low, the source holds `in_data` unchanged. `in_ready` rises during the last bit of the current word, so words sent back to back leave no gap in the serial stream. The serial side has no back-pressure: `ser_valid` only flags the cycles that carry a new line bit.

When `lock` is low, nothing advances. No word is accepted, no bit is emitted, and the line output stays frozen. When `lock` returns, the current word resumes where it stopped.

Top module: `svs_serializer`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `ser_valid` = 0 and `ser_bit` = 0. Reset also clears the scrambler history (nine zeros), the NRZI state (0) and the shift register, so a word accepted after reset starts from that clean state.
- R2: `in_ready` is high exactly when `lock` is high and the shift register holds at most one unsent bit (it is empty, or it is on the last bit of a word).
- R3: After a word is accepted, its bits are emitted one per locked cycle. Emission starts on the cycle after acceptance, goes bit 0 first and ends with bit 9. Each emitted bit appears on `ser_bit` with `ser_valid` = 1 one cycle after the edge that emits it.
- R4: Each emitted data bit d is scrambled as c = d XOR c[n-4] XOR c[n-9], where c[n-k] is the scrambled bit produced k emissions earlier. History that lies before reset counts as 0.
- R5: The line bit is the previous line bit XOR c. The line bit before the first emission after reset is 0.
- R6: With `clip_en` = 1, accepted values 0x000 to 0x003 are sent as 0x000, and 0x3FC to 0x3FF are sent as 0x3FF. All other values, and every value sent while `clip_en` = 0, are sent unchanged. Clipping takes place before scrambling.
- R7: For every edge at which `lock` is low, the next cycle has `ser_valid` = 0 and `ser_bit` unchanged. The scrambler, NRZI state and unsent bits are kept, so the stream resumes intact once `lock` returns high.
- R8: A word offered while the previous word is on its last bit is accepted on that edge. The serial output then carries the two words with `ser_valid` high on every cycle between them.
- R9: `in_data` has no effect unless `in_valid` and `in_ready` are both high at an edge. Data offered while not ready never reaches the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| lock | input | 1 | Clock-lock enable; low freezes the block |
| clip_en | input | 1 | Enables reserved-value clipping |
| in_valid | input | 1 | Parallel word offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 10 | Parallel video word |
| ser_bit | output | 1 | NRZI serial line bit |
| ser_valid | output | 1 | A new line bit was emitted |

## Verification
Two events can fall on the same edge: the last bit of one word is emitted, and the next word is loaded. The bench provokes this by holding `in_valid` high with a fresh word right after each handshake, so every back-to-back burst lands a load on a final-bit cycle. These edges are judged in two ways. A behavioural bit-queue model is compared with `ser_valid`, `ser_bit` and `in_ready` on every cycle. Separately, the actual line output is descrambled and NRZI-decoded in the bench, and the result must rebuild exactly the sequence of clipped words that was accepted, with no bit lost or repeated at word seams. This includes seams where `lock` drops in the middle of a word.

// File: rtl/svs_pkg.sv
package svs_pkg;
  localparam int SVS_WORD_W = 10;
  localparam int SVS_TAP_NEAR = 4;
  localparam int SVS_TAP_FAR = 9;
  localparam int SVS_CLIP_BITS = 2;

  typedef enum logic [1:0] {
    CLIP_PASS = 2'b00,
    CLIP_LOW  = 2'b01,
    CLIP_HIGH = 2'b10
  } clip_kind_e;
endpackage

// File: rtl/svs_clip.sv
module svs_clip #(
  parameter int W = svs_pkg::SVS_WORD_W,
  parameter int CB = svs_pkg::SVS_CLIP_BITS
) (
  input  logic         en,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] word_out
);
  import svs_pkg::*;

  clip_kind_e kind;

  generate
    if (CB == 0) begin : g_noclip
      always_comb kind = CLIP_PASS;
    end else begin : g_clip
      localparam int UPPER = W - CB;
      logic [UPPER-1:0] top_bits;
      always_comb begin
        top_bits = word_in[W-1:CB];
        if (!en)
          kind = CLIP_PASS;
        else if (top_bits == '0)
          kind = CLIP_LOW;
        else if (top_bits == '1)
          kind = CLIP_HIGH;
        else
          kind = CLIP_PASS;
      end
    end
  endgenerate

  always_comb begin
    unique case (kind)
      CLIP_LOW:  word_out = '0;
      CLIP_HIGH: word_out = '1;
      default:   word_out = word_in;
    endcase
  end
endmodule

// File: rtl/svs_shifter.sv
module svs_shifter #(
  parameter int W = svs_pkg::SVS_WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lock,
  input  logic         load,
  input  logic [W-1:0] load_word,
  output logic         ready,
  output logic         emit,
  output logic         bit_out
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [W-1:0]  shreg;
  logic [CW-1:0] left;

  assign emit    = lock && (left != '0);
  assign ready   = lock && (left <= ONE);
  assign bit_out = shreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      left  <= '0;
    end else if (load) begin
      shreg <= load_word;
      left  <= FULL;
    end else if (emit) begin
      shreg <= {1'b0, shreg[W-1:1]};
      left  <= left - ONE;
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    left <= FULL);
  p_load_fills_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (left == FULL));
  p_unlocked_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (!lock && !load) |=> ($stable(left) && $stable(shreg)));
endmodule

// File: rtl/svs_scrambler.sv
module svs_scrambler #(
  parameter int TAP_NEAR = svs_pkg::SVS_TAP_NEAR,
  parameter int TAP_FAR = svs_pkg::SVS_TAP_FAR
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic din,
  output logic dout
);
  logic [TAP_FAR-1:0] hist;

  generate
    if (TAP_NEAR < TAP_FAR) begin : g_two_taps
      assign dout = din ^ hist[TAP_NEAR-1] ^ hist[TAP_FAR-1];
    end else begin : g_one_tap
      assign dout = din ^ hist[TAP_FAR-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      hist <= '0;
    else if (adv)
      hist <= {hist[TAP_FAR-2:0], dout};
  end

  p_hist_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(hist));
  p_hist_age_r4: assert property (@(posedge clk) disable iff (rst)
    adv |=> (hist[TAP_FAR-1:1] == $past(hist[TAP_FAR-2:0])));
endmodule

// File: rtl/svs_nrzi.sv
module svs_nrzi (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic din,
  output logic line_q,
  output logic valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= adv;
      if (adv)
        line_q <= line_q ^ din;
    end
  end

  p_line_static_r7: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(line_q) && !valid_q));
  p_one_toggles_r5: assert property (@(posedge clk) disable iff (rst)
    (adv && din) |=> (line_q != $past(line_q)));
  p_zero_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (adv && !din) |=> $stable(line_q));
endmodule

// File: rtl/svs_serializer.sv
module svs_serializer #(
  parameter int W = svs_pkg::SVS_WORD_W,
  parameter int CB = svs_pkg::SVS_CLIP_BITS,
  parameter int TAP_NEAR = svs_pkg::SVS_TAP_NEAR,
  parameter int TAP_FAR = svs_pkg::SVS_TAP_FAR
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lock,
  input  logic         clip_en,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         ser_bit,
  output logic         ser_valid
);
  logic [W-1:0] clipped;
  logic         load;
  logic         emit;
  logic         raw_bit;
  logic         scr_bit;

  assign load = in_valid && in_ready;

  svs_clip #(.W(W), .CB(CB)) u_clip (
    .en       (clip_en),
    .word_in  (in_data),
    .word_out (clipped)
  );

  svs_shifter #(.W(W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .lock      (lock),
    .load      (load),
    .load_word (clipped),
    .ready     (in_ready),
    .emit      (emit),
    .bit_out   (raw_bit)
  );

  svs_scrambler #(.TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)) u_scr (
    .clk  (clk),
    .rst  (rst),
    .adv  (emit),
    .din  (raw_bit),
    .dout (scr_bit)
  );

  svs_nrzi u_nrzi (
    .clk     (clk),
    .rst     (rst),
    .adv     (emit),
    .din     (scr_bit),
    .line_q  (ser_bit),
    .valid_q (ser_valid)
  );

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!ser_valid && !ser_bit));
  p_ready_needs_lock_r2: assert property (@(posedge clk) disable iff (rst)
    !lock |-> !in_ready);
  p_unlocked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !lock |=> (!ser_valid && $stable(ser_bit)));
endmodule

// File: tb/sim_svs_serializer.sv
module sim_svs_serializer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lock = 1'b1;
  logic       clip_en = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_data = '0;
  logic       ser_bit;
  logic       ser_valid;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  svs_serializer u0 (
    .clk(clk), .rst(rst), .lock(lock), .clip_en(clip_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .ser_bit(ser_bit), .ser_valid(ser_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] clip_ref(input logic [9:0] v, input logic en);
    if (en && v <= 10'h003) return 10'h000;
    if (en && v >= 10'h3FC) return 10'h3FF;
    return v;
  endfunction

  // behavioural reference: queue of pending bits
  bit        bq[$];
  int        rem = 0;
  bit [8:0]  m_hist = '0;
  bit        m_line = 1'b0;
  bit        exp_valid = 1'b0;
  bit        exp_bit = 1'b0;
  bit        started = 1'b0;
  logic [9:0] exp_words[$];

  always @(posedge clk) begin
    bit acc;
    bit b;
    bit c;
    logic [9:0] w;
    started = 1'b1;
    if (rst) begin
      bq.delete();
      exp_words.delete();
      rem = 0; m_hist = '0; m_line = 1'b0;
      exp_valid = 1'b0; exp_bit = 1'b0;
    end else begin
      acc = in_valid && lock && (rem <= 1);
      if (lock && rem > 0) begin
        b = bq.pop_front();
        c = b ^ m_hist[3] ^ m_hist[8];
        m_hist = {m_hist[7:0], c};
        m_line = m_line ^ c;
        exp_bit = m_line;
        exp_valid = 1'b1;
        rem--;
      end else begin
        exp_valid = 1'b0;
      end
      if (acc) begin
        w = clip_ref(in_data, clip_en);
        exp_words.push_back(w);
        for (int i = 0; i < 10; i++) bq.push_back(w[i]);
        rem = 10;
      end
    end
  end

  // per-cycle comparison plus descrambler on the real line
  bit        d_prev = 1'b0;
  bit [8:0]  d_hist = '0;
  logic [9:0] d_word = '0;
  int        d_cnt = 0;
  int        rec_cnt = 0;
  int        rec_idx = 0;

  always @(negedge clk) begin
    bit c;
    bit d;
    logic [9:0] e;
    if (started) begin
      chk(ser_valid == exp_valid, "R3 R7 R8 ser_valid", ser_valid, exp_valid);
      chk(ser_bit == exp_bit, "R4 R5 ser_bit", ser_bit, exp_bit);
      chk(in_ready == (lock && rem <= 1), "R2 in_ready", in_ready, lock && rem <= 1);
    end
    if (rst) begin
      d_prev = 1'b0; d_hist = '0; d_word = '0; d_cnt = 0;
      rec_cnt = 0; rec_idx = 0;
    end else if (ser_valid) begin
      c = ser_bit ^ d_prev;
      d_prev = ser_bit;
      d = c ^ d_hist[3] ^ d_hist[8];
      d_hist = {d_hist[7:0], c};
      d_word[d_cnt] = d;
      d_cnt++;
      if (d_cnt == 10) begin
        e = (rec_idx < exp_words.size()) ? exp_words[rec_idx] : 10'h0;
        chk(d_word == e, "R3 R4 R5 R6 recovered word", d_word, e);
        rec_idx++;
        rec_cnt++;
        d_cnt = 0;
      end
    end
  end

  int sent_cnt = 0;

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic send_word(input logic [9:0] w);
    logic acc;
    in_valid = 1'b1;
    in_data = w;
    do begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk); #2;
    end while (!acc);
    sent_cnt++;
    in_valid = 1'b0;
    in_data = w ^ 10'h2D3;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    sent_cnt = 0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic held;
    // R1: reset state
    step();
    @(negedge clk);
    chk(!ser_valid, "R1 ser_valid in reset", ser_valid, 0);
    chk(!ser_bit, "R1 ser_bit in reset", ser_bit, 0);
    step();
    do_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 R2 ready after reset", in_ready, 1);
    step();

    // R8: back-to-back words, no clipping
    send_word(10'h000); send_word(10'h3FF); send_word(10'h2AA);
    send_word(10'h155); send_word(10'h001); send_word(10'h3FE);
    send_word(10'h200); send_word(10'h0F0);
    repeat (12) step();

    // R6: clipping enabled
    clip_en = 1'b1;
    send_word(10'h001); send_word(10'h003); send_word(10'h3FD);
    send_word(10'h3FE); send_word(10'h004); send_word(10'h3FB);
    send_word(10'h000); send_word(10'h3FF);
    repeat (12) step();
    clip_en = 1'b0;

    // R7: lock drops mid-word
    send_word(10'h3A5);
    repeat (4) step();
    lock = 1'b0;
    @(negedge clk);
    held = ser_bit;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!ser_valid, "R7 ser_valid while unlocked", ser_valid, 0);
      chk(ser_bit == held, "R7 ser_bit frozen", ser_bit, held);
      chk(!in_ready, "R2 R7 ready while unlocked", in_ready, 0);
    end
    // R9: junk offered while not ready must not be taken
    @(posedge clk); #2;
    in_valid = 1'b1; in_data = 10'h1C3;
    repeat (3) step();
    in_valid = 1'b0;
    lock = 1'b1;
    send_word(10'h0C5);
    send_word(10'h37A);
    repeat (12) step();

    // gaps between words, junk on data with valid low
    for (int k = 0; k < 4; k++) begin
      in_data = 10'h111 * (k + 1);
      repeat (k + 2) step();
      send_word(10'h05A + 10'(k * 97));
    end
    repeat (14) step();
    chk(rec_cnt == sent_cnt, "R9 words recovered equal words sent", rec_cnt, sent_cnt);

    // R1: reset in the middle of a word, then a clean restart
    send_word(10'h2F1);
    repeat (3) step();
    do_reset();
    @(negedge clk);
    chk(!ser_valid && !ser_bit, "R1 outputs after mid-word reset", {ser_valid, ser_bit}, 0);
    step();
    send_word(10'h000); send_word(10'h000); send_word(10'h3C3);
    repeat (14) step();
    chk(rec_cnt == sent_cnt, "R1 R9 words after restart", rec_cnt, sent_cnt);
    chk(rec_idx == exp_words.size(), "R3 all accepted words recovered", rec_idx, exp_words.size());

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule